// File: doc/BRIEF.md
# Shift-Register Return-Address Stack

This block keeps subroutine return addresses for a small sequencer. Each return address is a bank byte and a program-counter byte. A push takes the current bank and PC from the input pins and places them at the top of the stack. A pull removes the top entry and loads it into the bank and PC output registers.

The storage is a chain of registers with no read or write pointer. On a push, every entry moves one place deeper and the deepest entry is lost. On a pull, every entry moves one place toward the top and the deepest place is filled with zero. There are no full or empty flags. An overflow silently discards the oldest return address. An underflow returns zero and raises no error.

The caller decides whether to push, for example only when a call's branch condition holds. The caller also chooses which bank value to present on a far call. The stack itself only acts on its two strobes.

Top module: `retstack_shift`

## Requirements
- R1: A synchronous active-high `rst` clears every stack entry and both output registers to zero. After it, pulls return bank 0 and PC 0.
- R2: An entry is 16 bits, with the bank in bits 15:8 and the PC in bits 7:0. A push stores `{bank_in, pc_in}` as the new top entry.
- R3: Pulls return entries in reverse order of their pushes. The bank field goes to `bank_out` and the PC field goes to `pc_out`, one clock after the pull strobe is sampled.
- R4: The stack holds exactly 8 entries. A ninth push without an intervening pull discards the oldest entry, so the next 8 pulls return the 8 newest entries.
- R5: Each pull loads zero into the deepest entry. Once every stored entry has been pulled, further pulls return bank 0 and PC 0 and raise no error.
- R6: When `push_en` and `pull_en` are both high in one cycle, only the push takes effect. The output registers keep their values and the stack grows by one entry.
- R7: `bank_out` and `pc_out` change only on a pull. They hold their values during push and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push strobe; wins over pull_en |
| bank_in | input | 8 | Bank value to push |
| pc_in | input | 8 | PC value to push |
| pull_en | input | 1 | Pull strobe |
| bank_out | output | 8 | Bank of the most recently pulled entry |
| pc_out | output | 8 | PC of the most recently pulled entry |

## Verification
A corrupted entry deep in the chain stays hidden until enough pulls bring it to the top. A fault in slot k therefore first appears at the outputs on the (k+1)-th pull after it arises, as a wrong bank or PC value. A bad zero-fill or a wrong shift direction is exposed only by draining the stack past the entries that were actually pushed. For that reason the tests fill the stack to capacity and beyond, then pull more times than they pushed. A priority error or a stray load of the output registers shows up one cycle after the offending strobe, as a change on `bank_out` or `pc_out` in a cycle with no pull.

// File: rtl/ras_pkg.sv
package ras_pkg;
   typedef enum logic [1:0] {
      RAS_HOLD = 2'd0,
      RAS_PUSH = 2'd1,
      RAS_PULL = 2'd2
   } ras_op_e;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
   import ras_pkg::*;
(
   input  logic    push_en,
   input  logic    pull_en,
   output ras_op_e op
);
   // push outranks pull when both strobes arrive together
   always_comb begin
      if (push_en)      op = RAS_PUSH;
      else if (pull_en) op = RAS_PULL;
      else              op = RAS_HOLD;
   end
endmodule

// File: rtl/ras_cell.sv
module ras_cell
   import ras_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  ras_op_e      op,
   input  logic [W-1:0] from_above,
   input  logic [W-1:0] from_below,
   output logic [W-1:0] q
);
   initial begin
      if (W < 2) $error("ras_cell: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         unique case (op)
            RAS_PUSH: q <= from_above;
            RAS_PULL: q <= from_below;
            default:  q <= q;
         endcase
      end
   end
endmodule

// File: rtl/ras_outreg.sv
module ras_outreg
   import ras_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int PC_W   = 8,
   localparam int EW    = BANK_W + PC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  ras_op_e           op,
   input  logic [EW-1:0]     top_entry,
   output logic [BANK_W-1:0] bank_q,
   output logic [PC_W-1:0]   pc_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q <= '0;
         pc_q   <= '0;
      end else if (op == RAS_PULL) begin
         bank_q <= top_entry[EW-1:PC_W];
         pc_q   <= top_entry[PC_W-1:0];
      end
   end
endmodule

// File: rtl/retstack_shift.sv
module retstack_shift
   import ras_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 8,
   parameter int PC_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_en,
   input  logic [BANK_W-1:0] bank_in,
   input  logic [PC_W-1:0]   pc_in,
   input  logic              pull_en,
   output logic [BANK_W-1:0] bank_out,
   output logic [PC_W-1:0]   pc_out
);
   localparam int EW = BANK_W + PC_W;

   initial begin
      if (DEPTH < 2)   $error("retstack_shift: DEPTH must be at least 2");
      if (DEPTH > 256) $error("retstack_shift: DEPTH too large for a shift chain");
      if (BANK_W < 1 || PC_W < 1) $error("retstack_shift: field widths must be positive");
   end

   ras_op_e       op;
   logic [EW-1:0] new_entry;
   logic [EW-1:0] slot_q [DEPTH];

   assign new_entry = {bank_in, pc_in};

   ras_ctrl u_ctrl (
      .push_en (push_en),
      .pull_en (pull_en),
      .op      (op)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [EW-1:0] above_d;
      logic [EW-1:0] below_d;
      if (i == 0) begin : g_top
         assign above_d = new_entry;
      end else begin : g_mid
         assign above_d = slot_q[i-1];
      end
      if (i == DEPTH - 1) begin : g_deep
         assign below_d = '0;
      end else begin : g_link
         assign below_d = slot_q[i+1];
      end
      ras_cell #(.W(EW)) u_cell (
         .clk        (clk),
         .rst        (rst),
         .op         (op),
         .from_above (above_d),
         .from_below (below_d),
         .q          (slot_q[i])
      );
   end

   ras_outreg #(.BANK_W(BANK_W), .PC_W(PC_W)) u_out (
      .clk       (clk),
      .rst       (rst),
      .op        (op),
      .top_entry (slot_q[0]),
      .bank_q    (bank_out),
      .pc_q      (pc_out)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (slot_q[0] == '0 && slot_q[DEPTH-1] == '0 && bank_out == '0 && pc_out == '0));

   // R2
   push_top_chk: assert property (@(posedge clk) disable iff (rst)
      push_en |=> slot_q[0] == $past({bank_in, pc_in}));

   // R4
   push_shift_chk: assert property (@(posedge clk) disable iff (rst)
      push_en |=> slot_q[DEPTH-1] == $past(slot_q[DEPTH-2]));

   // R3
   pull_load_chk: assert property (@(posedge clk) disable iff (rst)
      (pull_en && !push_en) |=> {bank_out, pc_out} == $past(slot_q[0]));

   // R5
   zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (pull_en && !push_en) |=> slot_q[DEPTH-1] == '0);

   // R6 R7
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(pull_en && !push_en) |=> ($stable(bank_out) && $stable(pc_out)));
endmodule

// File: tb/retstack_shift_test.sv
module retstack_shift_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       push_en = 1'b0;
   logic       pull_en = 1'b0;
   logic [7:0] bank_in = '0;
   logic [7:0] pc_in = '0;
   logic [7:0] bank_out;
   logic [7:0] pc_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   retstack_shift uut (
      .clk      (clk),
      .rst      (rst),
      .push_en  (push_en),
      .bank_in  (bank_in),
      .pc_in    (pc_in),
      .pull_en  (pull_en),
      .bank_out (bank_out),
      .pc_out   (pc_out)
   );

   task automatic check(input string req, input logic [7:0] eb, input logic [7:0] ep);
      n_chk++;
      if (bank_out !== eb || pc_out !== ep) begin
         n_fail++;
         $display("FAIL %s: got bank=%02h pc=%02h, expected bank=%02h pc=%02h",
                  req, bank_out, pc_out, eb, ep);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; push_en = 1'b0; pull_en = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic do_push(input logic [7:0] b, input logic [7:0] p);
      @(negedge clk);
      push_en = 1'b1; bank_in = b; pc_in = p;
      @(negedge clk);
      push_en = 1'b0;
   endtask

   task automatic do_pull();
      @(negedge clk);
      pull_en = 1'b1;
      @(negedge clk);
      pull_en = 1'b0;
   endtask

   task automatic do_both(input logic [7:0] b, input logic [7:0] p);
      @(negedge clk);
      push_en = 1'b1; pull_en = 1'b1; bank_in = b; pc_in = p;
      @(negedge clk);
      push_en = 1'b0; pull_en = 1'b0;
   endtask

   // R1: reset clears outputs and stack contents
   task automatic t_reset();
      do_push(8'hA1, 8'hB2);
      do_pull();
      check("R1 pre", 8'hA1, 8'hB2);
      do_push(8'h11, 8'h22);
      do_push(8'h33, 8'h44);
      do_reset();
      check("R1 outputs", 8'h00, 8'h00);
      do_pull();
      check("R1 stack", 8'h00, 8'h00);
   endtask

   // R2, R3: field placement and LIFO order
   task automatic t_lifo();
      do_reset();
      do_push(8'h12, 8'h34);
      do_push(8'h56, 8'h78);
      do_push(8'h9A, 8'hBC);
      do_pull(); check("R2 R3 pull1", 8'h9A, 8'hBC);
      do_pull(); check("R3 pull2", 8'h56, 8'h78);
      do_pull(); check("R3 pull3", 8'h12, 8'h34);
   endtask

   // R4, R5: overflow drops oldest; drained stack yields zero
   task automatic t_overflow();
      do_reset();
      for (int i = 1; i <= 9; i++) do_push(8'(i), 8'(8'h10 + i));
      for (int i = 9; i >= 2; i--) begin
         do_pull();
         check("R4 overflow order", 8'(i), 8'(8'h10 + i));
      end
      do_pull(); check("R4 R5 oldest dropped", 8'h00, 8'h00);
   endtask

   // R5: zero fill after full drain, and pull of empty stack
   task automatic t_underflow();
      do_reset();
      for (int i = 0; i < 8; i++) do_push(8'hF0 + 8'(i), 8'hE0 + 8'(i));
      for (int i = 0; i < 8; i++) do_pull();
      check("R5 last real", 8'hF0, 8'hE0);
      do_pull(); check("R5 zero fill", 8'h00, 8'h00);
      do_pull(); check("R5 empty pull", 8'h00, 8'h00);
   endtask

   // R6: push wins over simultaneous pull
   task automatic t_simul();
      do_reset();
      do_push(8'h01, 8'h02);
      do_pull(); check("R6 setup", 8'h01, 8'h02);
      do_push(8'h03, 8'h04);
      do_both(8'h05, 8'h06);
      check("R6 outputs held", 8'h01, 8'h02);
      do_pull(); check("R6 pushed entry", 8'h05, 8'h06);
      do_pull(); check("R6 older entry", 8'h03, 8'h04);
      do_pull(); check("R6 empty", 8'h00, 8'h00);
   endtask

   // R7: outputs hold during push and idle
   task automatic t_hold();
      do_reset();
      do_push(8'hC3, 8'h3C);
      do_pull(); check("R7 setup", 8'hC3, 8'h3C);
      do_push(8'h77, 8'h88);
      check("R7 after push", 8'hC3, 8'h3C);
      repeat (4) @(negedge clk);
      check("R7 after idle", 8'hC3, 8'h3C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_lifo();
      t_overflow();
      t_underflow();
      t_simul();
      t_hold();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule